// File: doc/BRIEF.md
# SD Card SPI-Mode Multi-Block Write Sequencer

This block is the host side of the data phase of a multiple-block write to an SD card in SPI mode. It starts after the write command has been accepted. It keeps chip select low for the whole data phase and drives SCLK in mode 0: the clock idles low, MOSI changes while SCLK is low, and MISO is sampled on the rising edge. For each block it sends one all-ones gap byte, the start token and the payload bytes. The payload is taken from a byte-wide valid/ready stream. Two all-ones bytes follow in place of the CRC.

After each block the sequencer reads the card's data response and then clocks all-ones bytes for as long as the card holds MISO low while it programs. After the last block it sends a gap byte, the stop token and one filler byte. It then watches one further byte for busy. If that byte is all ones, the sequence ends at once. If it is not, the sequencer keeps clocking until MISO is high again. A rejected data response, or a busy period longer than a limit set at an input, sets the error output. Chip select is released at the end, and a one-cycle done pulse follows one clock later.

Top module: `sdspi_mbw_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, spi_cs_n is high, spi_sclk is low, spi_mosi is high, wr_ready is low and done is low.
- R2: A start with a non-zero blk_count pulls spi_cs_n low once. It stays low without interruption until the sequence ends, across every busy period.
- R3: Each block is sent as one 0xFF gap byte, the token 0xFC, BLOCK_BYTES stream bytes in arrival order, and then two 0xFF bytes.
- R4: A stream byte is taken in a cycle where wr_valid and wr_ready are both high. wr_ready is low in the following cycle and stays low until that byte has been shifted out.
- R5: The byte read right after the second CRC byte is the data response. It is accepted only if its bits [4:0] are 00101. Any other value sets error, sends no further blocks and goes on to the stop sequence.
- R6: After an accepted response, 0xFF bytes are clocked until a byte reads back as 0xFF. A byte containing any zero bit counts as busy. The next block's gap byte, or the stop sequence, follows.
- R7: After the last block the sequencer sends 0xFF, the stop token 0xFD and one 0xFF filler byte, then reads one window byte. If the window byte reads 0xFF, the sequence ends without a further byte.
- R8: If the window byte shows busy, 0xFF bytes are clocked until a byte reads 0xFF, and then the sequence ends.
- R9: busy_limit busy bytes in a row are tolerated. Busy byte number busy_limit+1 sets error and releases spi_cs_n at once, with no stop token.
- R10: done is high for exactly one cycle, one clock after spi_cs_n has risen. error is 0 from the cycle after start and holds its final value from done until the next start.
- R11: A start with blk_count equal to zero gives a done pulse with error 0, and spi_cs_n stays high.
- R12: A start pulse while a sequence is running is ignored.
- R13: spi_mosi changes only while spi_sclk is low, so the card samples every bit on a rising edge with the data already stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a sequence when idle |
| blk_count | input | CNT_W | Number of blocks to write, sampled at start |
| busy_limit | input | LIM_W | Busy bytes tolerated in a row |
| wr_data | input | 8 | Payload byte |
| wr_valid | input | 1 | wr_data holds a byte |
| wr_ready | output | 1 | Sequencer takes a payload byte |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Data to card |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_miso | input | 1 | Data from card |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Sequence ended on a rejected response or busy timeout |

## Verification
A card model in the bench reacts to the tokens on MOSI. It queues a chosen response byte and a chosen number of busy bytes, so the bench can count every byte clocked while CS is low against the expected total. A sequencer that stopped after a busy stop window, or that clocked an extra byte after a clean one, would get the byte count wrong. The cases covered are these: response codes that differ from the accepted code in bits [7:5] only (these must be accepted), rejected codes, busy exactly at the limit and one byte past it, busy after the stop token, a zero block count and a start during a sequence. A design that treated a timeout like a rejected response would send a stop token where none is expected. A design that ignored the high bits wrongly would flag 0xE5 as an error.

// File: rtl/sdspi_mbw_pkg.sv
package sdspi_mbw_pkg;

  localparam logic [7:0] TOK_BLOCK = 8'hFC;
  localparam logic [7:0] TOK_STOP  = 8'hFD;
  localparam logic [7:0] BYTE_IDLE = 8'hFF;
  localparam logic [4:0] RESP_GOOD = 5'b00101;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_GAP, SQ_TOKEN, SQ_DATA, SQ_CRC, SQ_RESP, SQ_BUSY,
    SQ_SGAP, SQ_STOK, SQ_SFILL, SQ_SWIN, SQ_SBUSY, SQ_FIN, SQ_DONE
  } seq_state_e;

  function automatic logic resp_accepted(input logic [7:0] r);
    return r[4:0] == RESP_GOOD;
  endfunction

endpackage

// File: rtl/sdspi_byte_shift.sv
module sdspi_byte_shift #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  output logic       done,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             active;
  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bit_cnt;
  logic [7:0]       tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= 8'hFF;
      rx      <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          tx_sh   <= tx;
          mosi    <= tx[7];
          div_cnt <= '0;
          bit_cnt <= '0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_cnt == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
            mosi   <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            tx_sh   <= {tx_sh[6:0], 1'b1};
            mosi    <= tx_sh[6];
          end
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end

  // R13
  mosi_steady_while_high_chk: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));

endmodule

// File: rtl/sdspi_busy_timer.sv
module sdspi_busy_timer #(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic [LIM_W-1:0] limit,
  output logic             at_limit
);
  logic [LIM_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + LIM_W'(1);
  end

  assign at_limit = (cnt == limit);

  // R9
  no_count_past_limit_chk: assert property (@(posedge clk) disable iff (rst)
    inc |-> (cnt < limit));

endmodule

// File: rtl/sdspi_mbw_seq.sv
module sdspi_mbw_seq
  import sdspi_mbw_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int CLK_DIV     = 2,
  parameter int CNT_W       = 16,
  parameter int LIM_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] blk_count,
  input  logic [LIM_W-1:0] busy_limit,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic             spi_sclk,
  output logic             spi_mosi,
  output logic             spi_cs_n,
  input  logic             spi_miso,
  output logic             done,
  output logic             error
);
  localparam int IDX_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLOCK_BYTES - 1);

  seq_state_e       state;
  logic             issued;
  logic [CNT_W-1:0] blk_left;
  logic [IDX_W-1:0] byte_idx;
  logic             crc_second;

  logic             x_start, x_done;
  logic [7:0]       x_tx, x_rx;
  logic             tmr_clr, tmr_inc, tmr_full;
  logic             rx_idle, busy_state;

  sdspi_byte_shift #(.CLK_DIV(CLK_DIV)) shift_i (
    .clk(clk), .rst(rst), .start(x_start), .tx(x_tx), .done(x_done),
    .rx(x_rx), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );

  sdspi_busy_timer #(.LIM_W(LIM_W)) timer_i (
    .clk(clk), .rst(rst), .clr(tmr_clr), .inc(tmr_inc),
    .limit(busy_limit), .at_limit(tmr_full)
  );

  assign rx_idle    = (x_rx == BYTE_IDLE);
  assign busy_state = (state == SQ_BUSY) || (state == SQ_SWIN) || (state == SQ_SBUSY);
  assign wr_ready   = (state == SQ_DATA) && !issued;

  always_comb begin
    x_start = 1'b0;
    x_tx    = BYTE_IDLE;
    if (!issued) begin
      unique case (state)
        SQ_GAP, SQ_CRC, SQ_RESP, SQ_BUSY,
        SQ_SGAP, SQ_SFILL, SQ_SWIN, SQ_SBUSY: x_start = 1'b1;
        SQ_TOKEN: begin x_start = 1'b1; x_tx = TOK_BLOCK; end
        SQ_STOK:  begin x_start = 1'b1; x_tx = TOK_STOP;  end
        SQ_DATA:  begin x_start = wr_valid; x_tx = wr_data; end
        default: ;
      endcase
    end
  end

  always_comb begin
    tmr_clr = x_done && (((state == SQ_RESP) && resp_accepted(x_rx)) || (state == SQ_STOK));
    tmr_inc = x_done && busy_state && !rx_idle && !tmr_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      issued     <= 1'b0;
      blk_left   <= '0;
      byte_idx   <= '0;
      crc_second <= 1'b0;
      spi_cs_n   <= 1'b1;
      done       <= 1'b0;
      error      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (x_done)       issued <= 1'b0;
      else if (x_start) issued <= 1'b1;

      unique case (state)
        SQ_IDLE: if (start) begin
          error <= 1'b0;
          if (blk_count == '0) begin
            state <= SQ_DONE;
          end else begin
            spi_cs_n <= 1'b0;
            blk_left <= blk_count;
            state    <= SQ_GAP;
          end
        end
        SQ_FIN: begin
          spi_cs_n <= 1'b1;
          state    <= SQ_DONE;
        end
        SQ_DONE: begin
          done  <= 1'b1;
          state <= SQ_IDLE;
        end
        default: if (x_done) begin
          unique case (state)
            SQ_GAP:   state <= SQ_TOKEN;
            SQ_TOKEN: begin state <= SQ_DATA; byte_idx <= '0; end
            SQ_DATA:  if (byte_idx == IDX_LAST) begin
                        state      <= SQ_CRC;
                        crc_second <= 1'b0;
                      end else begin
                        byte_idx <= byte_idx + IDX_W'(1);
                      end
            SQ_CRC:   if (crc_second) state <= SQ_RESP;
                      else crc_second <= 1'b1;
            SQ_RESP:  if (resp_accepted(x_rx)) state <= SQ_BUSY;
                      else begin error <= 1'b1; state <= SQ_SGAP; end
            SQ_BUSY:  if (rx_idle) begin
                        if (blk_left == CNT_W'(1)) state <= SQ_SGAP;
                        else begin
                          blk_left <= blk_left - CNT_W'(1);
                          state    <= SQ_GAP;
                        end
                      end else if (tmr_full) begin
                        error <= 1'b1;
                        state <= SQ_FIN;
                      end
            SQ_SGAP:  state <= SQ_STOK;
            SQ_STOK:  state <= SQ_SFILL;
            SQ_SFILL: state <= SQ_SWIN;
            SQ_SWIN, SQ_SBUSY:
                      if (rx_idle) state <= SQ_FIN;
                      else if (tmr_full) begin
                        error <= 1'b1;
                        state <= SQ_FIN;
                      end else state <= SQ_SBUSY;
            default:  state <= SQ_IDLE;
          endcase
        end
      endcase
    end
  end

  // R4
  ready_drops_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_ready);

  // R10
  done_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (spi_cs_n && $past(spi_cs_n)));

  // R10
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1
  clock_quiet_when_deselected_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

endmodule

// File: tb/sdspi_mbw_seq_tb_top.sv
`timescale 1ns/1ps
module sdspi_mbw_seq_tb_top;
  localparam int BLK = 4;

  typedef struct packed {
    logic [7:0] nblk, resp, bbusy, sbusy, lim, eblk, estop, eerr, ebytes;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd1, 8'hE5, 8'd0, 8'd0, 8'd8, 8'd1, 8'd1, 8'd0, 8'd14},
    '{8'd3, 8'h05, 8'd2, 8'd0, 8'd8, 8'd3, 8'd1, 8'd0, 8'd40},
    '{8'd2, 8'hE5, 8'd1, 8'd3, 8'd8, 8'd2, 8'd1, 8'd0, 8'd29},
    '{8'd3, 8'h0B, 8'd0, 8'd0, 8'd8, 8'd1, 8'd1, 8'd1, 8'd13},
    '{8'd1, 8'h0D, 8'd0, 8'd2, 8'd8, 8'd1, 8'd1, 8'd1, 8'd15},
    '{8'd1, 8'h05, 8'd5, 8'd0, 8'd2, 8'd1, 8'd0, 8'd1, 8'd12},
    '{8'd1, 8'h05, 8'd0, 8'd4, 8'd2, 8'd1, 8'd1, 8'd1, 8'd16},
    '{8'd2, 8'h05, 8'd2, 8'd2, 8'd2, 8'd2, 8'd1, 8'd0, 8'd30}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [15:0] blk_count = '0, busy_limit = '0;
  logic [7:0] wr_data = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic spi_sclk, spi_mosi, spi_cs_n, done, error;
  logic spi_miso = 1'b1;

  always #2 clk = ~clk;

  sdspi_mbw_seq #(.BLOCK_BYTES(BLK), .CLK_DIV(2), .CNT_W(16), .LIM_W(16)) dut_i (
    .clk(clk), .rst(rst), .start(start), .blk_count(blk_count), .busy_limit(busy_limit),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .done(done), .error(error)
  );

  int total = 0, failed = 0;
  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // card model state
  logic [7:0] c_rx, c_tx, last_b, pat_base, cfg_resp;
  int c_bits, c_txbit, cfg_bbusy, cfg_sbusy;
  logic [7:0] q [64];
  int qh, qt, in_data, data_n, data_tot, crc_n;
  int op_bytes, blocks_seen, stops_seen, gap_bad, data_bad, crc_bad;

  task automatic push(input logic [7:0] b);
    q[qt % 64] = b;
    qt++;
  endtask

  task automatic take_byte(input logic [7:0] b);
    if (in_data != 0) begin
      if (data_n < BLK) begin
        if (b != 8'(pat_base + data_tot)) data_bad++;
        data_n++;
        data_tot++;
      end else begin
        if (b != 8'hFF) crc_bad++;
        crc_n++;
        if (crc_n == 2) begin
          in_data = 0;
          push(cfg_resp);
          for (int i = 0; i < cfg_bbusy; i++) push(8'h00);
        end
      end
    end else if (b == 8'hFC) begin
      blocks_seen++;
      if (last_b != 8'hFF) gap_bad++;
      in_data = 1; data_n = 0; crc_n = 0;
    end else if (b == 8'hFD) begin
      stops_seen++;
      if (last_b != 8'hFF) gap_bad++;
      push(8'hFF);
      for (int i = 0; i < cfg_sbusy; i++) push(8'h00);
    end
    last_b = b;
  endtask

  initial forever begin
    @(posedge spi_sclk);
    if (spi_cs_n === 1'b0) begin
      c_rx = {c_rx[6:0], spi_mosi};
      c_bits++;
      if (c_bits == 8) begin
        c_bits = 0;
        op_bytes++;
        take_byte(c_rx);
      end
    end
  end

  initial forever begin
    @(negedge spi_sclk);
    if (spi_cs_n === 1'b0) begin
      c_txbit++;
      if (c_txbit == 8) begin
        c_txbit = 0;
        if (qh != qt) begin c_tx = q[qh % 64]; qh++; end
        else c_tx = 8'hFF;
      end
      spi_miso = c_tx[7 - c_txbit];
    end
  end

  // stream feeder
  int feed_idx, cyc;
  logic feed_en = 1'b0, hs = 1'b0;
  always @(posedge clk) hs <= wr_valid && wr_ready;
  initial forever begin
    @(negedge clk);
    cyc++;
    if (hs) feed_idx++;
    wr_data  = 8'(pat_base + feed_idx);
    wr_valid = feed_en && (cyc % 5 != 4);
  end

  // monitor
  int done_cnt, done_bad, cs_rises, cs_falls;
  logic prev_cs = 1'b1;
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (done) begin
        done_cnt++;
        if (!(spi_cs_n && prev_cs)) done_bad++;
      end
      if (spi_cs_n && !prev_cs) cs_rises++;
      if (!spi_cs_n && prev_cs) cs_falls++;
    end
    prev_cs = spi_cs_n;
  end

  task automatic clear_op(input int idx, input vec_t v);
    qh = 0; qt = 0; in_data = 0; data_tot = 0; last_b = 8'h00;
    c_bits = 0; c_txbit = 0; c_tx = 8'hFF; spi_miso = 1'b1;
    op_bytes = 0; blocks_seen = 0; stops_seen = 0;
    gap_bad = 0; data_bad = 0; crc_bad = 0;
    done_cnt = 0; done_bad = 0; cs_rises = 0; cs_falls = 0;
    pat_base = 8'(idx * 16 + 3);
    cfg_resp = v.resp; cfg_bbusy = int'(v.bbusy); cfg_sbusy = int'(v.sbusy);
    busy_limit = 16'(v.lim); blk_count = 16'(v.nblk);
    feed_idx = 0;
  endtask

  task automatic run_vec(input int idx, input vec_t v, input bit restart);
    int t;
    clear_op(idx, v);
    feed_en = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    chk("R10 error cleared after start", int'(error), 0);
    if (restart) begin
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    feed_en = 1'b0;
    chk("R10 done pulse count", done_cnt, 1);
    chk("R10 done one clock after CS release", done_bad, 0);
    chk("R5 R9 error flag held", int'(error), int'(v.eerr));
    chk("R6 R7 R8 R9 R12 bytes clocked", op_bytes, int'(v.ebytes));
    chk("R3 R5 blocks sent", blocks_seen, int'(v.eblk));
    chk("R7 R9 stop tokens", stops_seen, int'(v.estop));
    chk("R3 gap before token", gap_bad, 0);
    chk("R3 R13 payload bytes", data_bad, 0);
    chk("R3 CRC filler bytes", crc_bad, 0);
    chk("R4 stream bytes taken", feed_idx, int'(v.eblk) * BLK);
    chk("R2 CS selections", cs_falls, 1);
    chk("R2 CS releases", cs_rises, 1);
    chk("R2 CS high at end", int'(spi_cs_n), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", int'(spi_cs_n), 1);
    chk("R1 sclk", int'(spi_sclk), 0);
    chk("R1 mosi", int'(spi_mosi), 1);
    chk("R1 wr_ready", int'(wr_ready), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 error", int'(error), 0);

    foreach (VECS[i]) run_vec(i, VECS[i], 1'b0);

    // R11 zero block count
    clear_op(9, VECS[0]);
    blk_count = '0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (6) @(negedge clk);
    chk("R11 done on zero count", done_cnt, 1);
    chk("R11 no CS activity", cs_falls, 0);
    chk("R11 no bytes", op_bytes, 0);
    chk("R11 no error", int'(error), 0);

    // R12 start during a sequence is ignored
    run_vec(10, VECS[0], 1'b1);
    repeat (20) @(negedge clk);
    chk("R12 no second sequence", cs_falls, 1);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule